// File: doc/BRIEF.md
# Sticky Multi-Pattern Lane Checker

This block sits behind the capture stage of an 8-lane double-data-rate parallel receiver. On each clock it receives two already deserialized bytes: the half captured on the rising edge, which is the earlier word, and the half captured on the falling edge, which is the later word. The block compares the stream against eight programmable reference words. The transmitter is expected to send those same eight words over and over, in order. Any lane that ever carries a wrong bit is recorded in an error mask, one bit per lane. A bit in the mask stays set until software clears it. Training software loads the references, enables checking, clears the mask, lets traffic run, and reads the mask to find which lanes need skew adjustment.

A small register port holds the eight references at addresses 0 to 7, a control byte at address 8, and the error mask at address 9. A three-state machine does the comparison. IDLE holds the comparison logic still. HUNT waits for the first word equal to reference 0. TRACK compares every valid word against the next reference in cyclic order. The transitions are: IDLE to HUNT when checking is enabled; HUNT to TRACK on the first word equal to reference 0; HUNT or TRACK back to IDLE when checking is disabled.

Top module: `ddr_lane_checker`

## Requirements
- R1: Addresses 0 to 7 each hold an 8-bit reference word that can be written and read back. After reset, reference n holds 0x11 multiplied by (n+1), so the defaults run from 0x11 to 0x88.
- R2: After reset the error mask is 0x00, the control byte reads 0x00, and checking is off.
- R3: Writing a control byte with bit 2 set (for example 0x04) to address 8 enables checking. Checking stays enabled until a control byte with bit 2 clear is written.
- R4: In HUNT, words that differ from reference 0 are ignored. The first word equal to reference 0 becomes sequence position 0, whether it arrives in the rising half or in the falling half.
- R5: In TRACK, each following word is compared with the next reference, with position 7 wrapping to 0. Every lane that differs sets its bit in the mask.
- R6: Mask bits are sticky: a set bit stays at 1 while later words match.
- R7: Writing 0x00 to address 9 clears the mask. A nonzero write to address 9 leaves the mask unchanged.
- R8: While checking is disabled, the mask holds its value whatever data arrives. The sequence alignment is dropped, so re-enabling starts a new HUNT.
- R9: The mask is driven on err_mask and can be read at address 9. A word captured at a clock edge shows up in the mask right after that same edge.
- R10: Cycles with in_valid low are ignored and keep the current sequence position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational from cfg_addr |
| in_valid | input | 1 | Both halves of the data pair are valid this cycle |
| in_rise | input | 8 | Earlier word, captured on the rising edge |
| in_fall | input | 8 | Later word, captured on the falling edge |
| err_mask | output | 8 | Sticky per-lane error mask |

## Verification
Inputs change on the falling clock edge and are captured on the next rising edge. A data pair therefore changes err_mask right after the rising edge that captures it. The bench checks err_mask at the following falling edge, and only after the last pair of a scenario has been captured. A register write takes effect at its capture edge. Reads are combinational, so the bench checks them one nanosecond after changing the address. After enabling, the bench waits two idle cycles so the IDLE to HUNT step has finished before any data arrives.

// File: rtl/lane_chk_pkg.sv
package lane_chk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HUNT  = 2'd1,
        ST_TRACK = 2'd2
    } chk_state_t;

    function automatic int unsigned dflt_ref(input int unsigned k);
        return (k + 1) * 17;
    endfunction
endpackage

// File: rtl/lane_ref_bank.sv
module lane_ref_bank #(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    parameter int AW    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [AW-1:0]               addr,
    input  logic [LANES-1:0]            wdata,
    output logic [DEPTH-1:0][LANES-1:0] refs
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_ref
        always_ff @(posedge clk) begin
            if (!rst_n)
                refs[k] <= LANES'(lane_chk_pkg::dflt_ref(k));
            else if (wr && addr == AW'(k))
                refs[k] <= wdata;
        end
    end
endmodule

// File: rtl/lane_seq_fsm.sv
module lane_seq_fsm
    import lane_chk_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    parameter int IDXW  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        valid,
    input  logic [LANES-1:0]            rise,
    input  logic [LANES-1:0]            fall,
    input  logic [DEPTH-1:0][LANES-1:0] refs,
    output logic [LANES-1:0]            err_bits
);
    chk_state_t state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic [IDXW-1:0] idx_nx;

    assign idx_nx = idx_q + IDXW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        err_bits = '0;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (enable) state_d = ST_HUNT;
            end
            ST_HUNT: begin
                if (valid && rise == refs[0]) begin
                    err_bits = fall ^ refs[1 % DEPTH];
                    idx_d    = IDXW'(2 % DEPTH);
                    state_d  = ST_TRACK;
                end else if (valid && fall == refs[0]) begin
                    idx_d   = IDXW'(1 % DEPTH);
                    state_d = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (valid) begin
                    err_bits = (rise ^ refs[idx_q]) | (fall ^ refs[idx_nx]);
                    idx_d    = idx_q + IDXW'(2);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!enable) begin
            state_d  = ST_IDLE;
            err_bits = '0;
        end
    end

    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_IDLE);
    p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_HUNT && valid && rise == refs[0]) |=> state_q == ST_TRACK);
    p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_TRACK && !valid) |=> (state_q == ST_TRACK && $stable(idx_q)));
endmodule

// File: rtl/lane_err_acc.sv
module lane_err_acc #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LANES-1:0] err_in,
    output logic [LANES-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= (clr ? '0 : mask_q) | err_in;
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && err_in == '0) |=> mask_q == '0);
endmodule

// File: rtl/ddr_lane_checker.sv
module ddr_lane_checker #(
    parameter int LANES  = 8,
    parameter int DEPTH  = 8,
    parameter int EN_BIT = 2,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int AW    = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [LANES-1:0] cfg_wdata,
    output logic [LANES-1:0] cfg_rdata,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_rise,
    input  logic [LANES-1:0] in_fall,
    output logic [LANES-1:0] err_mask
);
    localparam logic [AW-1:0] ADDR_CTRL = AW'(DEPTH);
    localparam logic [AW-1:0] ADDR_MASK = AW'(DEPTH + 1);

    logic [DEPTH-1:0][LANES-1:0] refs;
    logic [LANES-1:0]            ctrl_q;
    logic [LANES-1:0]            err_bits;
    logic                        chk_en;
    logic                        mask_clr;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (cfg_wr && cfg_addr == ADDR_CTRL)
            ctrl_q <= cfg_wdata;
    end

    assign chk_en   = ctrl_q[EN_BIT];
    assign mask_clr = cfg_wr && cfg_addr == ADDR_MASK && cfg_wdata == '0;

    lane_ref_bank #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) u_refs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .refs(refs)
    );

    lane_seq_fsm #(.LANES(LANES), .DEPTH(DEPTH), .IDXW(IDXW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(chk_en), .valid(in_valid),
        .rise(in_rise), .fall(in_fall), .refs(refs), .err_bits(err_bits)
    );

    lane_err_acc #(.LANES(LANES)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(mask_clr), .err_in(err_bits),
        .mask_q(err_mask)
    );

    always_comb begin
        if (cfg_addr < AW'(DEPTH))
            cfg_rdata = refs[cfg_addr[IDXW-1:0]];
        else if (cfg_addr == ADDR_CTRL)
            cfg_rdata = ctrl_q;
        else if (cfg_addr == ADDR_MASK)
            cfg_rdata = err_mask;
        else
            cfg_rdata = '0;
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_en && !mask_clr) |=> $stable(err_mask));
    p_reset_r2: assert property (@(posedge clk)
        !rst_n |=> (err_mask == '0 && ctrl_q == '0));
endmodule

// File: tb/sim_ddr_lane_checker.sv
`timescale 1ns/1ps
module sim_ddr_lane_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       in_valid = 1'b0;
    logic [7:0] in_rise = '0;
    logic [7:0] in_fall = '0;
    logic [7:0] err_mask;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] mref [8];

    always #2.5 clk = ~clk;

    ddr_lane_checker u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_rise(in_rise), .in_fall(in_fall), .err_mask(err_mask)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic pair(input logic [7:0] r, input logic [7:0] f);
        in_valid = 1'b1; in_rise = r; in_fall = f;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_rise = 8'hA5; in_fall = 8'h5A;
            @(posedge clk); @(negedge clk);
        end
    endtask

    // eight words aligned on the rising half; word bi gets bits flipped by fl
    task automatic send_seq(input int bi, input logic [7:0] fl);
        logic [7:0] w [8];
        for (int i = 0; i < 8; i++) w[i] = mref[i] ^ ((i == bi) ? fl : 8'h00);
        for (int i = 0; i < 8; i += 2) pair(w[i], w[i+1]);
    endtask

    task automatic t_reset;
        check("R2 mask after reset", err_mask, 8'h00);
        rd_chk("R2 control after reset", 4'd8, 8'h00);
        for (int i = 0; i < 8; i++) rd_chk("R1 default reference", 4'(i), 8'(17 * (i + 1)));
    endtask

    task automatic t_regs;
        wr_reg(4'd3, 8'h3C);
        mref[3] = 8'h3C;
        rd_chk("R1 reference write", 4'd3, 8'h3C);
        rd_chk("R1 neighbour untouched", 4'd4, 8'h55);
    endtask

    task automatic t_disabled;
        send_seq(2, 8'hFF);
        check("R8 no errors while off", err_mask, 8'h00);
    endtask

    task automatic t_enable_hunt;
        wr_reg(4'd8, 8'h04);
        rd_chk("R3 control readback", 4'd8, 8'h04);
        idle(2);
        pair(8'h00, 8'hFF);
        pair(8'h12, 8'h77);
        check("R4 words before alignment ignored", err_mask, 8'h00);
        send_seq(-1, 8'h00);
        check("R5 clean sequence", err_mask, 8'h00);
        rd_chk("R3 still enabled", 4'd8, 8'h04);
    endtask

    task automatic t_error_sticky;
        send_seq(5, 8'h08);
        check("R5 lane 3 mismatch", err_mask, 8'h08);
        send_seq(-1, 8'h00);
        check("R6 sticky after clean words", err_mask, 8'h08);
        rd_chk("R9 mask readback", 4'd9, 8'h08);
    endtask

    task automatic t_clear;
        wr_reg(4'd9, 8'h05);
        check("R7 nonzero write ignored", err_mask, 8'h08);
        wr_reg(4'd9, 8'h00);
        check("R7 zero write clears", err_mask, 8'h00);
    endtask

    task automatic t_gap;
        pair(mref[0], mref[1]);
        pair(mref[2], mref[3]);
        idle(3);
        pair(mref[4], mref[5]);
        pair(mref[6] ^ 8'h40, mref[7]);
        check("R10 invalid cycles keep position", err_mask, 8'h40);
        wr_reg(4'd9, 8'h00);
    endtask

    task automatic t_wrap;
        send_seq(-1, 8'h00);
        send_seq(0, 8'h01);
        check("R5 wrap to reference 0", err_mask, 8'h01);
    endtask

    task automatic t_off_hold;
        wr_reg(4'd8, 8'h00);
        send_seq(1, 8'h80);
        check("R8 mask held while off", err_mask, 8'h01);
        wr_reg(4'd8, 8'h04);
        wr_reg(4'd9, 8'h00);
        idle(1);
        pair(8'h00, mref[0]);
        pair(mref[1], mref[2]);
        pair(mref[3], mref[4] ^ 8'h20);
        pair(mref[5], mref[6]);
        pair(mref[7], mref[0]);
        check("R4 alignment on falling half", err_mask, 8'h20);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mref[i] = 8'(17 * (i + 1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_disabled();
        t_enable_hunt();
        t_error_sticky();
        t_clear();
        t_gap();
        t_wrap();
        t_off_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule